// File: doc/BRIEF.md
# ADC Sample-and-Hold Timing Controller

This block generates the sample-control signal and the conversion window for a successive-approximation converter. It runs entirely on the conversion clock.

A 2-bit field selects the start trigger. The choices are a software start bit held inside the block and three timer outputs that arrive asynchronously. The selected trigger can be inverted. It then passes through a two-stage synchronizer, and its rising edge is detected.

The sample phase runs in one of two modes:
- **Extended mode:** the sample signal follows the synchronized trigger level.
- **Pulse mode:** the trigger edge starts a sampling timer. The timer length comes from one of two 4-bit fields, chosen by which half of the control-entry range the current entry index lies in.

A conversion window of exactly 13 cycles follows every sample phase. A one-cycle done pulse closes it. A trigger edge that arrives while the block is busy is reported as a timing overflow and is otherwise dropped.

Top module: `ss_timing_ctrl`

## Requirements
- R1: `trig_sel` picks the trigger source: 0 is the software start bit, 1 is `tmr_a1`, 2 is `tmr_b0`, 3 is `tmr_b1`. Activity on a source that is not selected starts nothing.
- R2: With `trig_inv`=1 the selected source is inverted before edge detection. A high-to-low change of the source then starts a sample, and holding the source high starts nothing.
- R3: A rising edge of a selected timer input, driven before clock edge k, raises `sample_o` after edge k+2, which is 3 cycles of latency. `sw_start_set` adds one cycle for the start-bit register, giving 4 cycles.
- R4: In extended mode (`pulse_mode`=0), `sample_o` stays high for as many cycles as the selected trigger stays high.
- R5: In pulse mode (`pulse_mode`=1), `sample_o` stays high for exactly 4*(N+1) cycles, where N is the selected 4-bit length field. The width of the trigger does not change this.
- R6: `samp_len_lo` applies when `entry_idx` is 0..7, and `samp_len_hi` applies when it is 8..15.
- R7: `conv_o` rises in the cycle after `sample_o` falls and stays high for exactly 13 cycles.
- R8: `busy_o` is high from the first sample cycle to the last conversion cycle. `done_o` is a one-cycle pulse in the first cycle after the conversion, and `busy_o` is already low in that cycle.
- R9: `sw_bit_o` is set by `sw_start_set` and cleared by `sw_start_clr`; set wins if both are high. The bit also clears itself on the edge that ends a conversion, the same edge that raises `done_o`.
- R10: A trigger rising edge detected while busy produces a one-cycle `ovf_o` pulse. It does not change the running sample or conversion length and does not start another sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_start_set | input | 1 | Sets the software start bit |
| sw_start_clr | input | 1 | Clears the software start bit |
| tmr_a1 | input | 1 | Timer trigger source 1 (asynchronous) |
| tmr_b0 | input | 1 | Timer trigger source 2 (asynchronous) |
| tmr_b1 | input | 1 | Timer trigger source 3 (asynchronous) |
| trig_sel | input | 2 | Trigger source select |
| trig_inv | input | 1 | Invert selected trigger |
| pulse_mode | input | 1 | 0 extended mode, 1 timed pulse mode |
| samp_len_lo | input | 4 | Sample length field for entries 0..7 |
| samp_len_hi | input | 4 | Sample length field for entries 8..15 |
| entry_idx | input | 4 | Index of the current control entry |
| sample_o | output | 1 | Sample-and-hold control |
| conv_o | output | 1 | Conversion window |
| busy_o | output | 1 | Sample or conversion in progress |
| done_o | output | 1 | One-cycle end-of-conversion pulse |
| ovf_o | output | 1 | One-cycle timing-overflow pulse |
| sw_bit_o | output | 1 | Current software start bit |

## Verification
The assertions assume the following about the inputs:
- `sw_start_set` and `sw_start_clr` are single-cycle pulses.
- Configuration fields change only while the block is idle.
- Sources are changed together with `trig_inv` whenever an unwanted edge has to be avoided.

The stimulus respects these assumptions as follows:
- It reprograms `trig_sel`, the mode and the length fields only between conversions, while every timer source is low.
- It injects overflow edges only in windows where the sample or conversion phase still has at least two cycles left.
- It draws random source, mode, length fields, entry index and trigger width from a fixed seed.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_CONV   = 2'd2
  } ss_state_e;

  typedef enum logic [1:0] {
    SRC_SOFT = 2'd0,
    SRC_TA1  = 2'd1,
    SRC_TB0  = 2'd2,
    SRC_TB1  = 2'd3
  } ss_src_e;
endpackage

// File: rtl/ss_rst_sync.sv
module ss_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] rs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = rs_q[STAGES-1];
endmodule

// File: rtl/ss_trig_front.sv
module ss_trig_front
  import ss_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_bit,
  input  logic       tmr_a1,
  input  logic       tmr_b0,
  input  logic       tmr_b1,
  input  logic [1:0] trig_sel,
  input  logic       trig_inv,
  output logic       trig_lvl,
  output logic       trig_rise
);
  logic                   pick;
  logic                   raw;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  // source selection, then optional inversion
  always_comb begin
    case (ss_src_e'(trig_sel))
      SRC_SOFT: pick = sw_bit;
      SRC_TA1:  pick = tmr_a1;
      SRC_TB0:  pick = tmr_b0;
      default:  pick = tmr_b1;
    endcase
    raw = pick ^ trig_inv;
  end

  // synchronizer chain into the conversion clock domain
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign trig_lvl  = sync_q[SYNC_STAGES-1];
  assign trig_rise = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/ss_down_cnt.sv
module ss_down_cnt #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         cnt_zero
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_zero = (cnt_q == '0);
endmodule

// File: rtl/ss_seq_fsm.sv
module ss_seq_fsm
  import ss_pkg::*;
#(
  parameter int CNT_W       = 7,
  parameter int CONV_CYCLES = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_rise,
  input  logic             trig_lvl,
  input  logic             pulse_mode,
  input  logic [CNT_W-1:0] sample_len,
  input  logic             cnt_zero,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_load_val,
  output logic             conv_end,
  output logic             sample_o,
  output logic             conv_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYCLES - 1);

  ss_state_e st_q, st_d;
  logic      mode_q, mode_d;
  logic      done_q, done_d;
  logic      ovf_q, ovf_d;
  logic      leave_sample;

  // next-state logic
  always_comb begin
    st_d         = st_q;
    mode_d       = mode_q;
    cnt_load     = 1'b0;
    cnt_load_val = '0;
    conv_end     = 1'b0;
    leave_sample = mode_q ? cnt_zero : ~trig_lvl;
    case (st_q)
      ST_IDLE: begin
        if (trig_rise) begin
          st_d   = ST_SAMPLE;
          mode_d = pulse_mode;
          if (pulse_mode) begin
            cnt_load     = 1'b1;
            cnt_load_val = sample_len - CNT_W'(1);
          end
        end
      end
      ST_SAMPLE: begin
        if (leave_sample) begin
          st_d         = ST_CONV;
          cnt_load     = 1'b1;
          cnt_load_val = CONV_LAST;
        end
      end
      ST_CONV: begin
        if (cnt_zero) begin
          st_d     = ST_IDLE;
          conv_end = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    done_d = conv_end;
    ovf_d  = trig_rise & (st_q != ST_IDLE);
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= 1'b0;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      done_q <= done_d;
      ovf_q  <= ovf_d;
    end
  end

  assign sample_o = (st_q == ST_SAMPLE);
  assign conv_o   = (st_q == ST_CONV);
  assign busy_o   = (st_q != ST_IDLE);
  assign done_o   = done_q;
  assign ovf_o    = ovf_q;
endmodule

// File: rtl/ss_timing_ctrl.sv
module ss_timing_ctrl #(
  parameter int ENTRY_W     = 4,
  parameter int SHT_W       = 4,
  parameter int SHT_STEP    = 4,
  parameter int CONV_CYCLES = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sw_start_set,
  input  logic               sw_start_clr,
  input  logic               tmr_a1,
  input  logic               tmr_b0,
  input  logic               tmr_b1,
  input  logic [1:0]         trig_sel,
  input  logic               trig_inv,
  input  logic               pulse_mode,
  input  logic [SHT_W-1:0]   samp_len_lo,
  input  logic [SHT_W-1:0]   samp_len_hi,
  input  logic [ENTRY_W-1:0] entry_idx,
  output logic               sample_o,
  output logic               conv_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               ovf_o,
  output logic               sw_bit_o
);
  localparam int NUM_ENTRIES = 1 << ENTRY_W;
  localparam int BANK_SPLIT  = NUM_ENTRIES / 2;
  localparam int MAX_SAMPLE  = SHT_STEP * (1 << SHT_W);
  localparam int MAX_LEN     = (MAX_SAMPLE > CONV_CYCLES) ? MAX_SAMPLE : CONV_CYCLES;
  localparam int CNT_W       = $clog2(MAX_LEN + 1);

  logic             rst_n_i;
  logic             sw_q, sw_d;
  logic             trig_lvl, trig_rise;
  logic [SHT_W-1:0] len_field;
  logic [CNT_W-1:0] sample_len;
  logic             cnt_load, cnt_zero, conv_end;
  logic [CNT_W-1:0] cnt_load_val;

  ss_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  // software start bit: set wins, cleared by software or at end of conversion
  always_comb begin
    if (sw_start_set)                     sw_d = 1'b1;
    else if (sw_start_clr || conv_end)    sw_d = 1'b0;
    else                                  sw_d = sw_q;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sw_q <= 1'b0;
    else          sw_q <= sw_d;
  end

  // per-bank sample length in steps of SHT_STEP clocks
  always_comb begin
    len_field  = (entry_idx >= ENTRY_W'(BANK_SPLIT)) ? samp_len_hi : samp_len_lo;
    sample_len = (CNT_W'(len_field) + CNT_W'(1)) * CNT_W'(SHT_STEP);
  end

  ss_trig_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .sw_bit    (sw_q),
    .tmr_a1    (tmr_a1),
    .tmr_b0    (tmr_b0),
    .tmr_b1    (tmr_b1),
    .trig_sel  (trig_sel),
    .trig_inv  (trig_inv),
    .trig_lvl  (trig_lvl),
    .trig_rise (trig_rise)
  );

  ss_down_cnt #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .load     (cnt_load),
    .load_val (cnt_load_val),
    .cnt_zero (cnt_zero)
  );

  ss_seq_fsm #(.CNT_W(CNT_W), .CONV_CYCLES(CONV_CYCLES)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .trig_rise    (trig_rise),
    .trig_lvl     (trig_lvl),
    .pulse_mode   (pulse_mode),
    .sample_len   (sample_len),
    .cnt_zero     (cnt_zero),
    .cnt_load     (cnt_load),
    .cnt_load_val (cnt_load_val),
    .conv_end     (conv_end),
    .sample_o     (sample_o),
    .conv_o       (conv_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .ovf_o        (ovf_o)
  );

  assign sw_bit_o = sw_q;
endmodule

// File: rtl/ss_timing_chk.sv
module ss_timing_chk #(
  parameter int CONV_CYCLES = 13
) (
  input logic clk,
  input logic rst_n,
  input logic sw_start_set,
  input logic sample_o,
  input logic conv_o,
  input logic busy_o,
  input logic done_o,
  input logic ovf_o,
  input logic sw_bit_o
);
  logic [7:0] conv_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      conv_run <= '0;
    else if (conv_o) conv_run <= conv_run + 8'd1;
    else             conv_run <= '0;
  end

  // R7
  conv_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_o) |-> $past(sample_o));

  // R7
  conv_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_o) |-> (conv_run == 8'(CONV_CYCLES)));

  // R8
  done_after_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(conv_o) && !conv_o && !busy_o));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10
  ovf_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> $past(busy_o));

  // R9
  sw_autoclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !$past(sw_start_set)) |-> !sw_bit_o);
endmodule

bind ss_timing_ctrl ss_timing_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sw_start_set (sw_start_set),
  .sample_o     (sample_o),
  .conv_o       (conv_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .ovf_o        (ovf_o),
  .sw_bit_o     (sw_bit_o)
);

// File: tb/tb_ss_timing_ctrl.sv
`timescale 1ns/1ps
module tb_ss_timing_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sw_start_set, sw_start_clr;
  logic       tmr_a1, tmr_b0, tmr_b1;
  logic [1:0] trig_sel;
  logic       trig_inv, pulse_mode;
  logic [3:0] samp_len_lo, samp_len_hi, entry_idx;
  logic       sample_o, conv_o, busy_o, done_o, ovf_o, sw_bit_o;

  int errs = 0, checks = 0, cyc = 0;
  int ovf_seen = 0, samp_rises = 0;
  logic samp_prev = 1'b0;

  always #2.5 clk = ~clk;

  ss_timing_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sw_start_set(sw_start_set), .sw_start_clr(sw_start_clr),
    .tmr_a1(tmr_a1), .tmr_b0(tmr_b0), .tmr_b1(tmr_b1), .trig_sel(trig_sel),
    .trig_inv(trig_inv), .pulse_mode(pulse_mode), .samp_len_lo(samp_len_lo),
    .samp_len_hi(samp_len_hi), .entry_idx(entry_idx), .sample_o(sample_o),
    .conv_o(conv_o), .busy_o(busy_o), .done_o(done_o), .ovf_o(ovf_o), .sw_bit_o(sw_bit_o)
  );

  always @(negedge clk) begin
    if (ovf_o) ovf_seen++;
    if (sample_o && !samp_prev) samp_rises++;
    samp_prev = sample_o;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_lat(input int sel);
    return (sel == 0) ? 4 : 3;
  endfunction

  function automatic int exp_len(input bit mode, input int lo, input int hi, input int idx, input int h);
    if (!mode) return h;
    return 4 * (((idx >= 8) ? hi : lo) + 1);
  endfunction

  task automatic set_src(input int sel, input logic v);
    case (sel)
      1: tmr_a1 = v;
      2: tmr_b0 = v;
      3: tmr_b1 = v;
      default: ;
    endcase
  endtask

  task automatic pulse_src(input int sel, input int h);
    set_src(sel, 1'b1);
    fork
      begin
        repeat (h) @(negedge clk);
        set_src(sel, 1'b0);
      end
    join_none
  endtask

  task automatic fire(input int sel, input bit mode, input int h);
    if (sel == 0) begin
      sw_start_set = 1'b1;
      fork
        begin
          for (int i = 0; i < (mode ? 1 : h); i++) begin
            @(negedge clk);
            if (i == 0) sw_start_set = 1'b0;
          end
          if (!mode) begin
            sw_start_clr = 1'b1;
            @(negedge clk);
            sw_start_clr = 1'b0;
          end
        end
      join_none
    end else begin
      pulse_src(sel, h);
    end
  endtask

  // measure latency, sample width and conversion; optional overflow injection
  task automatic measure(input int e_lat, input int e_w, input string wtag, input int inj_sel,
                         input int inj_s, input int inj_c, input bit sw_chk);
    int lat = 0, w = 0, c = 0;
    do begin @(negedge clk); lat++; end while (!sample_o && lat < 40);
    chk(lat == e_lat, "R1 R3 start latency", lat, e_lat);
    chk(busy_o == 1'b1, "R8 busy during sample", busy_o, 1);
    if (sw_chk) chk(sw_bit_o == 1'b1, "R9 start bit held during sample", sw_bit_o, 1);
    while (sample_o && w < 200) begin
      w++;
      if (w == inj_s) pulse_src(inj_sel, 1);
      @(negedge clk);
    end
    chk(w == e_w, wtag, w, e_w);
    chk(conv_o == 1'b1, "R7 conversion right after sample", conv_o, 1);
    while (conv_o && c < 100) begin
      c++;
      if (c == inj_c) pulse_src(inj_sel, 1);
      @(negedge clk);
    end
    chk(c == 13, "R7 conversion length", c, 13);
    chk(done_o == 1'b1, "R8 done pulse after conversion", done_o, 1);
    chk(busy_o == 1'b0, "R8 busy low at done", busy_o, 0);
    if (sw_chk) chk(sw_bit_o == 1'b0, "R9 start bit auto clear", sw_bit_o, 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R8 done lasts one cycle", done_o, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic run_case(input int sel, input bit mode, input int lo, input int hi,
                          input int idx, input int h);
    string tag;
    trig_sel = 2'(sel); pulse_mode = mode;
    samp_len_lo = 4'(lo); samp_len_hi = 4'(hi); entry_idx = 4'(idx);
    repeat (2) @(negedge clk);
    tag = mode ? "R5 R6 pulse-mode sample length" : "R4 extended sample length";
    fire(sel, mode, h);
    measure(exp_lat(sel), exp_len(mode, lo, hi, idx, h), tag, 0, 0, 0, (sel == 0) && mode);
  endtask

  initial begin
    int r0, r1, o0;
    void'($urandom(32'd2718));
    rst_n = 1'b0; sw_start_set = 0; sw_start_clr = 0;
    tmr_a1 = 0; tmr_b0 = 0; tmr_b1 = 0; trig_sel = 0; trig_inv = 0; pulse_mode = 0;
    samp_len_lo = 0; samp_len_hi = 0; entry_idx = 0;
    repeat (3) @(negedge clk);
    chk({sample_o, conv_o, busy_o, done_o, ovf_o, sw_bit_o} == 6'b0, "R8 reset state idle",
        int'({sample_o, conv_o, busy_o, done_o, ovf_o, sw_bit_o}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // directed pulse-mode boundaries (R5, R6)
    run_case(1, 1'b1, 0, 9, 0, 1);
    run_case(2, 1'b1, 3, 15, 8, 2);
    run_case(3, 1'b1, 11, 2, 7, 3);
    run_case(1, 1'b1, 1, 15, 15, 1);
    // extended mode, shortest and longer
    run_case(2, 1'b0, 5, 5, 0, 1);
    run_case(3, 1'b0, 5, 5, 0, 7);
    // software start in both modes (R9)
    run_case(0, 1'b1, 2, 0, 3, 1);
    run_case(0, 1'b0, 0, 0, 0, 4);

    // R1: unselected sources are ignored
    trig_sel = 2'd2; pulse_mode = 1'b1;
    @(negedge clk);
    r0 = samp_rises;
    pulse_src(1, 2); pulse_src(3, 2);
    repeat (10) @(negedge clk);
    chk(samp_rises == r0 && !busy_o, "R1 unselected sources ignored", samp_rises - r0, 0);

    // R9: set/clear of start bit while not selected
    trig_sel = 2'd1;
    sw_start_set = 1'b1; @(negedge clk); sw_start_set = 1'b0;
    chk(sw_bit_o == 1'b1, "R9 start bit set", sw_bit_o, 1);
    sw_start_clr = 1'b1; @(negedge clk); sw_start_clr = 1'b0;
    chk(sw_bit_o == 1'b0, "R9 start bit cleared", sw_bit_o, 0);
    sw_start_set = 1'b1; sw_start_clr = 1'b1; @(negedge clk);
    sw_start_set = 1'b0; sw_start_clr = 1'b0;
    chk(sw_bit_o == 1'b1, "R9 set wins over clear", sw_bit_o, 1);
    sw_start_clr = 1'b1; @(negedge clk); sw_start_clr = 1'b0;
    repeat (5) @(negedge clk);
    chk(!busy_o, "R1 start bit ignored when timer selected", busy_o, 0);

    // R2: inverted polarity
    trig_sel = 2'd1; pulse_mode = 1'b0;
    @(negedge clk);
    r0 = samp_rises;
    tmr_a1 = 1'b1; trig_inv = 1'b1;
    repeat (6) @(negedge clk);
    chk(samp_rises == r0 && !busy_o, "R2 high source with inversion starts nothing",
        samp_rises - r0, 0);
    tmr_a1 = 1'b0;
    fork begin repeat (5) @(negedge clk); tmr_a1 = 1'b1; end join_none
    measure(3, 5, "R2 R4 inverted low pulse sets sample width", 0, 0, 0, 1'b0);
    tmr_a1 = 1'b0; trig_inv = 1'b0;
    repeat (4) @(negedge clk);

    // R10: overflow edges during sample and conversion
    trig_sel = 2'd3; pulse_mode = 1'b1; samp_len_lo = 4'd7; entry_idx = 4'd2;
    repeat (2) @(negedge clk);
    r0 = samp_rises; o0 = ovf_seen;
    pulse_src(3, 1);
    measure(3, 32, "R10 sample length unchanged by overflow", 3, 6, 4, 1'b0);
    r1 = samp_rises;
    chk(ovf_seen - o0 == 2, "R10 overflow pulses", ovf_seen - o0, 2);
    chk(r1 - r0 == 1, "R10 no extra sample from overflow", r1 - r0, 1);

    // random mix
    o0 = ovf_seen;
    for (int it = 0; it < 40; it++) begin
      int sel, lo, hi, idx, h;
      bit mode;
      sel  = int'($urandom % 4);
      mode = 1'($urandom % 2);
      lo   = int'($urandom % 16);
      hi   = int'($urandom % 16);
      idx  = int'($urandom % 16);
      h    = mode ? 1 + int'($urandom % 3) : 1 + int'($urandom % 8);
      run_case(sel, mode, lo, hi, idx, h);
    end
    chk(ovf_seen == o0, "R10 no spurious overflow", ovf_seen - o0, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule